// File: doc/BRIEF.md
# HDLC Receive Station Address Filter

This block sits in an HDLC receive path, downstream of flag hunting and zero-bit removal. It accepts a byte stream in which the first byte of each frame is marked as frame start and the last byte before the closing flag is marked as frame end. It decides, frame by frame, whether the frame is addressed to this station.

It compares the leading one to four address bytes against a programmable station address under a programmable care mask. Frames that match are forwarded byte by byte to a receive FIFO write port, unchanged. The forwarded bytes include the address, the control byte and the two trailing check bytes. Frames that do not match are discarded silently up to their closing byte.

Address bytes are held in a small internal buffer until the configured address length has arrived. They are released only when the frame is accepted. While a new frame's address is held, the tail of an earlier accepted frame keeps draining. The input carries no backpressure.

Top module: `hdlc_addr_filter`

## Requirements
- R1: After reset, `fwd_valid` and `short_pulse` are low, and no byte is forwarded until an accepted frame arrives.
- R2: The address length is `cfg_len`+1 bytes (values 0 to 3 select 1 to 4 bytes). The k-th received address byte (k counting from 0 at the frame-start byte) is compared with `cfg_station[8k+7:8k]`.
- R3: A `cfg_care` bit of 1 makes the matching station bit take part in the comparison, and a 0 makes it a don't-care. With `cfg_care` all zero, every frame that is long enough is accepted.
- R4: The bytes of an accepted frame appear on `fwd_data` in arrival order, each exactly once and unchanged. This covers the address, control, information and check bytes.
- R5: A frame whose address does not match produces no `fwd_valid` cycle at all.
- R6: `fwd_last` is high on exactly the forwarded byte that carried `rx_eof`, and low on every other forwarded byte.
- R7: A frame that ends before the full address length has arrived forwards nothing. It raises `short_pulse` for one cycle, once per such frame.
- R8: Bytes that arrive while no frame is open and that lack `rx_sof` are ignored and produce no output.
- R9: Frames may follow each other with no idle cycle between them, and the bytes may arrive with gaps. No byte of an accepted frame is lost or reordered, even while the next frame's address bytes are held back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Input byte strobe |
| rx_data | input | 8 | Input byte |
| rx_sof | input | 1 | Byte is the first after the opening flag |
| rx_eof | input | 1 | Byte is the last before the closing flag |
| cfg_station | input | 8*MAX_ADDR_BYTES | Station address, first address byte in the low lane |
| cfg_care | input | 8*MAX_ADDR_BYTES | Care mask, 1 = compare this bit |
| cfg_len | input | LEN_W | Address length minus one |
| fwd_valid | output | 1 | Forwarded byte strobe |
| fwd_data | output | 8 | Forwarded byte |
| fwd_last | output | 1 | Forwarded byte closes its frame |
| short_pulse | output | 1 | One-cycle pulse for a frame shorter than the address |

## Verification
The hardest case to reach from the ports has two parts at once. An accepted frame's tail is still draining from the buffer while the next frame's address bytes are being held, and that next frame may then be rejected, so the held bytes must be rewound without touching the older ones. The stimulus gets there by sending four-byte-address frames back to back with no idle cycle. Accepts and rejects alternate, once with no gaps and once with gaps inserted after every byte. Short frames, stray bytes outside a frame and single-byte frames complete the boundary set.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ADDR,
      ST_PASS,
      ST_DROP
   } af_state_e;

   typedef struct packed {
      logic [BYTE_W-1:0] data;
      logic              last;
   } af_item_t;
endpackage

// File: rtl/hdlc_af_match.sv
module hdlc_af_match
   import hdlc_af_pkg::*;
#(
   parameter int MAX_ADDR_BYTES = 4,
   parameter int LEN_W          = 2
) (
   input  logic [BYTE_W-1:0]                rx_byte,
   input  logic [LEN_W-1:0]                 lane_sel,
   input  logic [BYTE_W*MAX_ADDR_BYTES-1:0] station,
   input  logic [BYTE_W*MAX_ADDR_BYTES-1:0] care,
   output logic                             lane_hit
);
   logic [MAX_ADDR_BYTES-1:0] hits;
   logic [BYTE_W-1:0]         care_sel;

   for (genvar g = 0; g < MAX_ADDR_BYTES; g++) begin : g_lane
      assign hits[g] = ((rx_byte ^ station[g*BYTE_W +: BYTE_W]) & care[g*BYTE_W +: BYTE_W]) == '0;
   end

   assign lane_hit = hits[lane_sel];
   assign care_sel = care[lane_sel*BYTE_W +: BYTE_W];

   // R3
   always_comb begin
      if (care_sel == '0) begin
         no_care_hit_chk: assert (lane_hit);
      end
   end
endmodule

// File: rtl/hdlc_af_buf.sv
module hdlc_af_buf
   import hdlc_af_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     push,
   input  af_item_t push_item,
   input  logic     mark,
   input  logic     hold,
   input  logic     rewind,
   output af_item_t head,
   output logic     drain
);
   localparam int PW = $clog2(DEPTH);

   af_item_t      mem [DEPTH];
   logic [PW:0]   wr_ptr, rd_ptr, mark_ptr, level;

   assign level = wr_ptr - rd_ptr;
   assign head  = mem[rd_ptr[PW-1:0]];
   assign drain = (level != '0) && !(hold && (rd_ptr == mark_ptr));

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr[PW-1:0]] <= push_item;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         mark_ptr <= '0;
      end else begin
         if (mark)        mark_ptr <= wr_ptr;
         if (rewind)      wr_ptr   <= mark_ptr;
         else if (push)   wr_ptr   <= wr_ptr + 1'b1;
         if (drain)       rd_ptr   <= rd_ptr + 1'b1;
      end
   end

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (level < (PW+1)'(DEPTH)));
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
   import hdlc_af_pkg::*;
#(
   parameter  int MAX_ADDR_BYTES = 4,
   localparam int LEN_W  = (MAX_ADDR_BYTES > 1) ? $clog2(MAX_ADDR_BYTES) : 1,
   localparam int ADDR_W = BYTE_W * MAX_ADDR_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_data,
   input  logic              rx_sof,
   input  logic              rx_eof,
   input  logic [ADDR_W-1:0] cfg_station,
   input  logic [ADDR_W-1:0] cfg_care,
   input  logic [LEN_W-1:0]  cfg_len,
   output logic              fwd_valid,
   output logic [BYTE_W-1:0] fwd_data,
   output logic              fwd_last,
   output logic              short_pulse
);
   localparam int BUF_DEPTH = 1 << $clog2(2 * MAX_ADDR_BYTES);
   localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_ADDR_BYTES - 1);

   if (MAX_ADDR_BYTES < 1 || MAX_ADDR_BYTES > 4) begin : g_bad_len
      $error("MAX_ADDR_BYTES must lie in 1..4");
   end

   af_state_e        state, state_d;
   logic [LEN_W-1:0] cnt, cnt_d, idx, eff_len;
   logic             ok, ok_d, lane_hit, at_end;
   logic             push, mark, rewind, short_d, drain;
   af_item_t         push_item, head;

   assign eff_len   = (cfg_len > LEN_CAP) ? LEN_CAP : cfg_len;
   assign idx       = (state == ST_ADDR) ? cnt : '0;
   assign at_end    = (idx == eff_len);
   assign push_item = '{data: rx_data, last: rx_eof};

   hdlc_af_match #(.MAX_ADDR_BYTES(MAX_ADDR_BYTES), .LEN_W(LEN_W)) u_match (
      .rx_byte (rx_data),
      .lane_sel(idx),
      .station (cfg_station),
      .care    (cfg_care),
      .lane_hit(lane_hit)
   );

   hdlc_af_buf #(.DEPTH(BUF_DEPTH)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .push_item(push_item),
      .mark     (mark),
      .hold     (state == ST_ADDR),
      .rewind   (rewind),
      .head     (head),
      .drain    (drain)
   );

   always_comb begin
      state_d = state;
      cnt_d   = cnt;
      ok_d    = ok;
      push    = 1'b0;
      mark    = 1'b0;
      rewind  = 1'b0;
      short_d = 1'b0;
      if (rx_valid) begin
         case (state)
            ST_IDLE: begin
               if (rx_sof) begin
                  mark = 1'b1;
                  if (at_end) begin
                     push    = lane_hit;
                     state_d = rx_eof ? ST_IDLE : (lane_hit ? ST_PASS : ST_DROP);
                  end else if (rx_eof) begin
                     short_d = 1'b1;
                  end else begin
                     push    = 1'b1;
                     cnt_d   = LEN_W'(1);
                     ok_d    = lane_hit;
                     state_d = ST_ADDR;
                  end
               end
            end
            ST_ADDR: begin
               if (at_end) begin
                  push    = ok && lane_hit;
                  rewind  = !(ok && lane_hit);
                  state_d = rx_eof ? ST_IDLE : ((ok && lane_hit) ? ST_PASS : ST_DROP);
               end else if (rx_eof) begin
                  short_d = 1'b1;
                  rewind  = 1'b1;
                  state_d = ST_IDLE;
               end else begin
                  push  = 1'b1;
                  cnt_d = cnt + 1'b1;
                  ok_d  = ok && lane_hit;
               end
            end
            ST_PASS: begin
               push = 1'b1;
               if (rx_eof) state_d = ST_IDLE;
            end
            default: begin
               if (rx_eof) state_d = ST_IDLE;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cnt         <= '0;
         ok          <= 1'b0;
         fwd_valid   <= 1'b0;
         fwd_data    <= '0;
         fwd_last    <= 1'b0;
         short_pulse <= 1'b0;
      end else begin
         state       <= state_d;
         cnt         <= cnt_d;
         ok          <= ok_d;
         fwd_valid   <= drain;
         short_pulse <= short_d;
         if (drain) begin
            fwd_data <= head.data;
            fwd_last <= head.last;
         end
      end
   end

   // R7
   short_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      short_pulse |-> $past(rx_valid && rx_eof));

   // R4
   fwd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> $past(drain));

   // R2
   addr_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR) |-> (cnt != '0));
endmodule

// File: tb/tb_hdlc_addr_filter.sv
module tb_hdlc_addr_filter;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
   logic [7:0]  rx_data = '0;
   logic [31:0] cfg_station = '0, cfg_care = '0;
   logic [1:0]  cfg_len = '0;
   logic        fwd_valid, fwd_last, short_pulse;
   logic [7:0]  fwd_data;

   int checks = 0, fails = 0, exp_short = 0, seen_short = 0;
   bit done = 1'b0;
   logic [7:0] frm [$];
   logic [7:0] exp_data [$];
   logic       exp_last [$];
   string      exp_tag [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   hdlc_addr_filter dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_sof(rx_sof), .rx_eof(rx_eof), .cfg_station(cfg_station),
      .cfg_care(cfg_care), .cfg_len(cfg_len), .fwd_valid(fwd_valid),
      .fwd_data(fwd_data), .fwd_last(fwd_last), .short_pulse(short_pulse)
   );

   // monitor and scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (short_pulse) seen_short++;
         if (fwd_valid) begin
            checks++;
            if (exp_data.size() == 0) begin
               fails++;
               $display("FAIL R5 unexpected byte: actual %02h expected none", fwd_data);
            end else begin
               automatic logic [7:0] d = exp_data.pop_front();
               automatic logic       l = exp_last.pop_front();
               automatic string      t = exp_tag.pop_front();
               if (fwd_data !== d) begin
                  fails++;
                  $display("FAIL %s data: actual %02h expected %02h", t, fwd_data, d);
               end else if (fwd_last !== l) begin
                  fails++;
                  $display("FAIL R6 last marker: actual %0b expected %0b", fwd_last, l);
               end
            end
         end
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         tick();
         rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
      end
   endtask

   task automatic config_set(input logic [31:0] st, input logic [31:0] cr, input logic [1:0] ln);
      cfg_station = st; cfg_care = cr; cfg_len = ln;
   endtask

   // driver: predicts from the requirements, then drives frm
   task automatic send(input string tag, input int gap);
      automatic int  n = int'(cfg_len) + 1;
      automatic bit  hit = 1'b1;
      if (frm.size() < n) begin
         exp_short++;                       // R7
      end else begin
         for (int k = 0; k < n; k++)        // R2 R3
            if (((frm[k] ^ cfg_station[8*k +: 8]) & cfg_care[8*k +: 8]) != 8'h00) hit = 1'b0;
         if (hit)
            for (int i = 0; i < frm.size(); i++) begin
               exp_data.push_back(frm[i]);
               exp_last.push_back(i == frm.size() - 1);
               exp_tag.push_back(tag);
            end
      end
      for (int i = 0; i < frm.size(); i++) begin
         tick();
         rx_valid = 1'b1; rx_data = frm[i];
         rx_sof = (i == 0); rx_eof = (i == frm.size() - 1);
         for (int g = 0; g < gap; g++) begin
            tick();
            rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
         end
      end
   endtask

   task automatic stray(input int n);                // R8
      for (int i = 0; i < n; i++) begin
         tick();
         rx_valid = 1'b1; rx_data = 8'h5A; rx_sof = 1'b0; rx_eof = (i % 2 == 1);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 40000);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL R9 watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      checks++;
      if (fwd_valid !== 1'b0 || short_pulse !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset: actual %0b%0b expected 00", fwd_valid, short_pulse);
      end

      // R4 one-byte address, exact match
      config_set(32'h0000005A, 32'h000000FF, 2'd0);
      frm = '{8'h5A, 8'h03, 8'h10, 8'h20, 8'hC1, 8'hC2}; send("R4", 0);
      // R5 mismatch
      frm = '{8'h5B, 8'h03, 8'h10, 8'hC1, 8'hC2}; send("R5", 0);
      // R6 single-byte accepted frame
      frm = '{8'h5A}; send("R6", 0);
      idle(12);

      // R3 partial mask
      config_set(32'h0000005A, 32'h0000000F, 2'd0);
      frm = '{8'h3A, 8'h77, 8'hE0, 8'hE1}; send("R3", 1);
      frm = '{8'h3B, 8'h77, 8'hE0, 8'hE1}; send("R3", 0);
      idle(12);

      // R2 four-byte address, byte order
      config_set(32'h11223344, 32'hFFFFFFFF, 2'd3);
      frm = '{8'h44, 8'h33, 8'h22, 8'h11, 8'h13, 8'h99, 8'hAB, 8'hCD}; send("R2", 0);
      frm = '{8'h44, 8'h33, 8'h22, 8'h12, 8'h13, 8'hAB, 8'hCD}; send("R2", 0);
      frm = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h13, 8'hAB, 8'hCD}; send("R2", 0);
      frm = '{8'h44, 8'h33, 8'h22, 8'h11, 8'h55}; send("R2", 2);
      idle(12);

      // R3 zero mask accepts everything
      config_set(32'hDEADBEEF, 32'h00000000, 2'd2);
      frm = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05}; send("R3", 0);
      frm = '{8'hF0, 8'h0F, 8'hAA}; send("R3", 0);
      idle(12);

      // R7 short frames
      config_set(32'h00332211, 32'h00FFFFFF, 2'd2);
      frm = '{8'h11, 8'h22}; send("R7", 0);
      frm = '{8'h11}; send("R7", 1);
      frm = '{8'h11, 8'h22, 8'h33, 8'h9C}; send("R7", 0);
      idle(12);

      // R8 stray bytes outside any frame
      config_set(32'h0000005A, 32'h000000FF, 2'd0);
      stray(5);
      frm = '{8'h5A, 8'h42, 8'h43}; send("R8", 0);
      stray(3);
      idle(12);

      // R9 back-to-back frames, alternating accept and reject
      config_set(32'hA1B2C3D4, 32'hFFFFFFFF, 2'd3);
      for (int gp = 0; gp < 3; gp += 2) begin
         for (int f = 0; f < 6; f++) begin
            frm = '{8'hD4, 8'hC3, 8'hB2, (f % 2 == 0) ? 8'hA1 : 8'hA0,
                    8'(f), 8'(8'h60 + f), 8'hF1, 8'hF2};
            if (f == 4) frm = '{8'hD4, 8'hC3, 8'hB2, 8'hA1, 8'h7E};
            send("R9", gp);
         end
      end
      idle(30);

      checks++;
      if (seen_short != exp_short) begin
         fails++;
         $display("FAIL R7 short pulses: actual %0d expected %0d", seen_short, exp_short);
      end
      checks++;
      if (exp_data.size() != 0) begin
         fails++;
         $display("FAIL R9 missing bytes: actual %0d left expected 0", exp_data.size());
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule